// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from a small set of sources and presents one request line and the number of the winning source to a processor. Eight sources form a group. Their relative order comes from a priority word of eight 3-bit slots, and each slot names the group member that holds that rank. The remaining sources rank below the group in a fixed order. A single programmable override number can lift any one source above all the others.

Software reaches the controller through a word-addressed 32-bit register bus. This bus carries the mask, force, pending, sense, slot and override settings and the vector readback. The first few sources may be external lines. Each external line can be set to edge detection, and a latched edge stays pending until software writes a one to that source's pending bit. Every other source follows its synchronised input level.

Top module: `grp_intc`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0, and mask, force, sense and override are all 0. The slot word reads back with slot p holding index p.
- R2: Source number s (1..NSRC) uses word bit 31−s in the mask (word 3), pending (word 2) and force (word 4) registers.
- R3: A source takes part in arbitration only while its mask bit is 1.
- R4: A level-sensed source is pending while its input, passed through a two-flop synchroniser, is high. Writing one to its pending bit has no effect.
- R5: External line i (source number i+1, i < NEXT) is edge-sensed when bit 15−i of the sense register (word 6) is 1. A rising edge stays pending after the input falls, until a one is written to its pending bit.
- R6: Group source g (0..7) is source number g+1. The slot word (word 5) holds slot p at bit offset 29−3p for p<4 and at 13−3(p−4) for p≥4. Slot 0 is the highest rank, and the winner is the group source named in the lowest-numbered slot whose source is active.
- R7: The sources numbered 9 and up rank below every slotted group source, and among themselves the lower number wins. A group source named in no slot ranks below all of them.
- R8: Bits 30:24 of the configuration word (word 0) name an override source. When that number is nonzero and its source is active, it wins over all others.
- R9: vec_o and word 1 bits 6:0 give the winner one clock after the active set changes. The value 0 means nothing is pending. irq_o is 1 exactly when, on the previous clock, some source was pending and unmasked.
- R10: A 1 in the force register makes that source pending regardless of its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Raw source inputs, index j is source number j+1 |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_waddr |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 7 | Winning source number, 0 for none |

## Verification
The bench reprograms the slot word so that the slot order no longer matches the source order, and then checks that the slot order decides the winner. A design that ranked by source number would report the wrong vector here. It leaves a group source out of every slot while a fixed source is active, which catches a design that drops the orphan entirely or ranks it above the fixed sources. It checks that an override on a masked source does not win, that an edge event outlives its input pulse but is cleared by the write-one, and that the same write has no effect on a level source. A design with a wrong bit position for the mask, force or pending bits, or for the sense bit, reports the wrong source or none.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;
  localparam int NGRP = 8;
  localparam int SLOT_W = 3;

  typedef enum logic [2:0] {
    W_CFG   = 3'd0,
    W_VEC   = 3'd1,
    W_PEND  = 3'd2,
    W_MASK  = 3'd3,
    W_FORCE = 3'd4,
    W_SLOT  = 3'd5,
    W_SENSE = 3'd6
  } word_e;

  // low bit of slot p inside the slot word
  function automatic int slot_lsb(input int p);
    return (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
  endfunction

  function automatic logic [31:0] slot_reset();
    logic [31:0] w;
    w = '0;
    for (int p = 0; p < NGRP; p++) w[slot_lsb(p) +: SLOT_W] = SLOT_W'(p);
    return w;
  endfunction
endpackage

// File: rtl/grp_intc_capture.sv
module grp_intc_capture #(
  parameter int NSRC = 12,
  parameter int NEXT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NEXT-1:0] sense,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] pend
);
  for (genvar j = 0; j < NSRC; j++) begin : g_src
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= src_i[j];
        s2 <= s1;
      end
    end
    if (j < NEXT) begin : g_ext
      logic s3, latch;
      logic rise_w;
      assign rise_w = s2 & ~s3;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s3    <= 1'b0;
          latch <= 1'b0;
        end else begin
          s3    <= s2;
          latch <= rise_w | (latch & ~ack[j]);
        end
      end
      assign pend[j] = sense[j] ? latch : s2;
    end else begin : g_int
      assign pend[j] = s2;
    end
  end
endmodule

// File: rtl/grp_intc_arb.sv
module grp_intc_arb
  import grp_intc_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic [NSRC-1:0] act,
  input  logic [31:0]     slots,
  input  logic [6:0]      ovr,
  output logic [6:0]      win
);
  logic [NGRP-1:0] assigned;

  always_comb begin
    assigned = '0;
    for (int p = 0; p < NGRP; p++) assigned[slots[slot_lsb(p) +: SLOT_W]] = 1'b1;
  end

  // lowest rank first, each higher rank overwrites
  always_comb begin
    logic [SLOT_W-1:0] g;
    win = '0;
    for (int u = NGRP - 1; u >= 0; u--)
      if (act[u] && !assigned[u]) win = 7'(u + 1);
    for (int f = NSRC - 1; f >= NGRP; f--)
      if (act[f]) win = 7'(f + 1);
    for (int p = NGRP - 1; p >= 0; p--) begin
      g = slots[slot_lsb(p) +: SLOT_W];
      if (act[g]) win = 7'(int'(g) + 1);
    end
    if (ovr != '0 && int'(ovr) <= NSRC && act[ovr - 7'd1]) win = ovr;
  end
endmodule

// File: rtl/grp_intc.sv
module grp_intc
  import grp_intc_pkg::*;
#(
  parameter int NFIX = 4,
  parameter int NEXT = 4,
  parameter int NSRC = NGRP + NFIX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_we,
  input  logic [2:0]      bus_waddr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic [6:0]      vec_o
);
  function automatic logic [NSRC-1:0] word_to_src(input logic [31:0] w);
    logic [NSRC-1:0] v;
    for (int j = 0; j < NSRC; j++) v[j] = w[30 - j];
    return v;
  endfunction

  function automatic logic [31:0] src_to_word(input logic [NSRC-1:0] v);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < NSRC; j++) w[30 - j] = v[j];
    return w;
  endfunction

  logic [NSRC-1:0] mask_q, force_q, raw_pend, pend_w, act_w, ack_w;
  logic [NEXT-1:0] sense_q;
  logic [31:0]     slot_q;
  logic [6:0]      ovr_q, win_w, win_q;
  logic            irq_q;
  logic [31:0]     sense_word;

  assign ack_w  = (bus_we && bus_waddr == W_PEND) ? word_to_src(bus_wdata) : '0;
  assign pend_w = raw_pend | force_q;
  assign act_w  = pend_w & mask_q;

  always_comb begin
    sense_word = '0;
    for (int i = 0; i < NEXT; i++) sense_word[15 - i] = sense_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= '0;
      sense_q <= '0;
      slot_q  <= slot_reset();
      ovr_q   <= '0;
    end else if (bus_we) begin
      case (bus_waddr)
        W_CFG:   ovr_q   <= bus_wdata[30:24];
        W_MASK:  mask_q  <= word_to_src(bus_wdata);
        W_FORCE: force_q <= word_to_src(bus_wdata);
        W_SLOT:  slot_q  <= bus_wdata;
        W_SENSE: for (int i = 0; i < NEXT; i++) sense_q[i] <= bus_wdata[15 - i];
        default: ;
      endcase
    end
  end

  grp_intc_capture #(.NSRC(NSRC), .NEXT(NEXT)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sense(sense_q),
    .ack(ack_w), .pend(raw_pend)
  );

  grp_intc_arb #(.NSRC(NSRC)) u_arb (
    .act(act_w), .slots(slot_q), .ovr(ovr_q), .win(win_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      win_q <= win_w;
      irq_q <= |act_w;
    end
  end

  assign vec_o = win_q;
  assign irq_o = irq_q;

  always_comb begin
    case (bus_waddr)
      W_CFG:   bus_rdata = {1'b0, ovr_q, 24'b0};
      W_VEC:   bus_rdata = {25'b0, win_q};
      W_PEND:  bus_rdata = src_to_word(pend_w);
      W_MASK:  bus_rdata = src_to_word(mask_q);
      W_FORCE: bus_rdata = src_to_word(force_q);
      W_SLOT:  bus_rdata = slot_q;
      W_SENSE: bus_rdata = sense_word;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/grp_intc_chk.sv
module grp_intc_chk #(
  parameter int NSRC = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] act,
  input logic [6:0]      ovr,
  input logic            irq,
  input logic [6:0]      vec
);
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |=> irq);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|act) |=> !irq);

  assert_vec_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec) <= NSRC);

  assert_override_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr != 7'd0 && int'(ovr) <= NSRC && act[ovr - 7'd1]) |=> vec == $past(ovr));

  assert_quiet_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> vec == 7'd0);
endmodule

bind grp_intc grp_intc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act_w), .ovr(ovr_q), .irq(irq_o), .vec(vec_o)
);

// File: tb/sim_grp_intc.sv
module sim_grp_intc;
  localparam int NSRC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic bus_we = 1'b0;
  logic [2:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  logic [6:0] vec_o;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    string      tag;
    logic [6:0] vec;
    logic       irq;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  grp_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  function automatic logic [31:0] sbit(input int id);
    return 32'h1 << (31 - id);
  endfunction

  function automatic logic [31:0] slots_word(input int s0, s1, s2, s3, s4, s5, s6, s7);
    int s[8];
    logic [31:0] w;
    s = '{s0, s1, s2, s3, s4, s5, s6, s7};
    w = '0;
    for (int p = 0; p < 8; p++) begin
      int top = (p < 4) ? 31 - 3 * p : 15 - 3 * (p - 4);
      w[top -: 3] = 3'(s[p]);
    end
    return w;
  endfunction

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      nchk++;
      if (vec_o !== e.vec || irq_o !== e.irq) begin
        nfail++;
        $display("FAIL %s: actual vec=%0d irq=%0b expected vec=%0d irq=%0b",
                 e.tag, vec_o, irq_o, e.vec, e.irq);
      end
    end
  end

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int v, input logic i);
    exp_t e;
    e.tag = tag;
    e.vec = 7'(v);
    e.irq = i;
    sb.push_back(e);
    settle(2);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1;
    bus_waddr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_waddr = a;
    #1;
    nchk++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", tag, bus_rdata, exp);
    end
  endtask

  logic [31:0] all_mask;

  initial begin
    all_mask = '0;
    for (int id = 1; id <= NSRC; id++) all_mask |= sbit(id);
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    expect_out("R1 reset outputs", 0, 1'b0);
    rd_check("R1 reset slots", 3'd5, slots_word(0, 1, 2, 3, 4, 5, 6, 7));
    rd_check("R1 reset mask", 3'd3, 32'h0);
    rd_check("R1 reset override", 3'd0, 32'h0);

    // R3 masked source stays quiet
    src_i[5] = 1'b1;
    settle(4);
    expect_out("R3 masked source", 0, 1'b0);

    // R2 R4 level source visible once unmasked
    wr(3'd3, all_mask);
    rd_check("R2 mask bit layout", 3'd3, 32'h7FF8_0000);
    settle(3);
    expect_out("R4 level source id6", 6, 1'b1);
    rd_check("R2 pending bit id6", 3'd2, sbit(6));
    wr(3'd2, sbit(6));
    settle(3);
    expect_out("R4 ack ignored on level", 6, 1'b1);
    src_i[5] = 1'b0;
    settle(4);
    expect_out("R4 level released", 0, 1'b0);

    // R6 slot order
    src_i[2] = 1'b1;
    src_i[6] = 1'b1;
    settle(4);
    expect_out("R6 default slots id3 over id7", 3, 1'b1);
    wr(3'd5, slots_word(6, 2, 0, 1, 3, 4, 5, 7));
    settle(3);
    expect_out("R6 slot0 names id7", 7, 1'b1);
    rd_check("R9 vector word", 3'd1, 32'd7);

    // R7 unassigned group below fixed sources
    wr(3'd5, slots_word(0, 0, 0, 0, 0, 0, 0, 0));
    src_i[9] = 1'b1;
    settle(4);
    expect_out("R7 fixed id10 over orphans", 10, 1'b1);
    src_i[9] = 1'b0;
    settle(4);
    expect_out("R7 lowest orphan id3", 3, 1'b1);
    src_i[2] = 1'b0;
    src_i[6] = 1'b0;
    wr(3'd5, slots_word(0, 1, 2, 3, 4, 5, 6, 7));
    src_i[7] = 1'b1;
    src_i[11] = 1'b1;
    settle(4);
    expect_out("R7 group id8 over fixed id12", 8, 1'b1);
    src_i[7] = 1'b0;
    src_i[8] = 1'b1;
    settle(4);
    expect_out("R7 fixed id9 over id12", 9, 1'b1);
    src_i[8] = 1'b0;

    // R8 override
    src_i[0] = 1'b1;
    settle(4);
    expect_out("R8 no override id1", 1, 1'b1);
    wr(3'd0, 32'd12 << 24);
    settle(3);
    expect_out("R8 override id12", 12, 1'b1);
    wr(3'd3, all_mask & ~sbit(12));
    settle(3);
    expect_out("R8 masked override loses", 1, 1'b1);
    src_i[0] = 1'b0;
    src_i[11] = 1'b0;
    wr(3'd0, 32'h0);
    wr(3'd3, all_mask);
    settle(4);
    expect_out("R9 idle again", 0, 1'b0);

    // R5 edge latch on line 2 (id3), sense bit 13
    wr(3'd6, 32'h1 << 13);
    src_i[2] = 1'b1;
    settle(2);
    src_i[2] = 1'b0;
    settle(5);
    expect_out("R5 edge held after pulse", 3, 1'b1);
    rd_check("R5 pending id3 latched", 3'd2, sbit(3));
    wr(3'd2, sbit(3));
    settle(2);
    expect_out("R5 edge cleared by ack", 0, 1'b0);
    rd_check("R5 pending cleared", 3'd2, 32'h0);

    // R10 force
    wr(3'd4, sbit(11));
    settle(2);
    expect_out("R10 forced id11", 11, 1'b1);
    rd_check("R10 force in pending", 3'd2, sbit(11));
    wr(3'd4, 32'h0);
    settle(2);
    expect_out("R10 force removed", 0, 1'b0);

    settle(4);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    nfail++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule